// File: doc/BRIEF.md
# Five-stage pipelined integer core

This block is a small in-order integer core that runs a six-instruction subset: add, subtract, bitwise and, bitwise or, word load and word store. Each instruction moves through five stages: fetch, decode with register read, execute or address calculation, memory access and write-back. The stages are separated by four pipeline registers. The instruction memory, the data memory and the 32-entry register file all sit inside the block.

Before a run, a test environment fills the two memories and the register file through load ports while reset is held. It then releases reset and watches two observation ports. The retire port shows each register write, and the store port shows each data-memory write.

The core has no hazard detection, forwarding or stalling. An instruction placed one or two slots after the instruction that produces its source reads the old register value. Software must space dependent instructions with no-ops.

Top module: `pipe5_core`

## Requirements
- R1: Instruction fields are as follows. The opcode is in bits 31..26, rs in 25..21, rt in 20..16 and rd in 15..11, and bits 15..0 form a signed immediate. For opcode 1 (add), 2 (sub), 3 (and) and 4 (or), register rd receives rs op rt, with 32-bit wrap-around for add and sub.
- R2: Opcode 5 (load) writes register rt with the data-memory word at index rs + sign-extended immediate, using the low address bits. For example, base 42 with offset 50 reads word 92. Opcode 6 (store) writes register rt to that same index and writes no register. A load issued in the slot right after a store to the same word sees the stored value.
- R3: Instruction k (at word k, counted from reset release) appears on the retire port after the (k+4)-th rising edge, and its register is updated at the (k+5)-th edge. A store appears on the store port after edge k+3. Back-to-back instructions retire on consecutive cycles.
- R4: The register written and reported at write-back is the write-back instruction's own destination: rd for ALU operations and rt for loads. Retire events come out in program order.
- R5: There is no forwarding or interlock. An instruction one or two slots after its producer reads the producer's old register value.
- R6: A register written at write-back is visible to an instruction decoding in the same cycle, so a gap of three slots reads the new value.
- R7: Register 0 always reads as zero. A write to it is dropped and produces no retire event.
- R8: While reset is asserted, and in the first cycles after release, the retire and store ports stay idle. Reset sets the PC to 0 and empties the pipeline. The PC then advances by 4 each cycle, and instruction word pc/4 is fetched.
- R9: Opcode 0 and every opcode other than 1 to 6 act as a no-op: no register write and no store.
- R10: The load ports write instruction memory, data memory and registers one word per clock while reset is held. The values loaded are the ones the program then reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_imem_we | input | 1 | Load-port write enable for instruction memory |
| ld_imem_addr | input | IMEM_AW | Instruction memory word index |
| ld_imem_data | input | 32 | Instruction word to write |
| ld_dmem_we | input | 1 | Load-port write enable for data memory |
| ld_dmem_addr | input | DMEM_AW | Data memory word index |
| ld_dmem_data | input | 32 | Data word to write |
| ld_reg_we | input | 1 | Load-port write enable for the register file |
| ld_reg_addr | input | 5 | Register number to write |
| ld_reg_data | input | 32 | Register value to write |
| peek_reg_addr | input | 5 | Register number to read back |
| peek_reg_data | output | 32 | Current value of that register |
| peek_dmem_addr | input | DMEM_AW | Data memory word index to read back |
| peek_dmem_data | output | 32 | Current word at that index |
| ret_valid | output | 1 | A register write happens at this cycle's closing edge |
| ret_reg | output | 5 | Register being written |
| ret_data | output | 32 | Value being written |
| st_valid | output | 1 | A data-memory store happens at this cycle's closing edge |
| st_addr | output | DMEM_AW | Word index being stored |
| st_data | output | 32 | Word being stored |

## Verification
The bench builds the core with a 64-word instruction memory and a 128-word data memory. This keeps the load phase short while leaving room for the word-92 access of the offset-addressing case. The program ends long before the PC could wrap to word 0.

With those sizes, one straight-line program reaches several cases:
- stale reads at gaps of one and two slots, and a fresh read at a gap of three;
- a load whose address comes from a stale base;
- a store followed by a load of the same word in the next slot;
- a write to register 0;
- an undefined opcode.

Each expected retire and store carries its exact cycle, so latency and one-per-cycle throughput are checked on every event.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN   = 32;
    localparam int ILEN   = 32;
    localparam int REG_AW = 5;
    localparam int OP_W   = 6;
    localparam int IMM_W  = 16;

    localparam logic [OP_W-1:0] OP_NOP   = 6'd0;
    localparam logic [OP_W-1:0] OP_ADD   = 6'd1;
    localparam logic [OP_W-1:0] OP_SUB   = 6'd2;
    localparam logic [OP_W-1:0] OP_AND   = 6'd3;
    localparam logic [OP_W-1:0] OP_OR    = 6'd4;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'd5;
    localparam logic [OP_W-1:0] OP_STORE = 6'd6;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

    // control bundle produced once in decode
    typedef struct packed {
        alu_op_e           alu_op;
        logic              mem_rd;
        logic              mem_wr;
        logic              reg_wr;
        logic [REG_AW-1:0] dst;
    } ctrl_t;

    typedef struct packed {
        logic [ILEN-1:0] instr;
    } ifid_t;

    typedef struct packed {
        ctrl_t           ctrl;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] imm;
    } idex_t;

    // only the fields the memory and write-back stages use
    typedef struct packed {
        logic              mem_rd;
        logic              mem_wr;
        logic              reg_wr;
        logic [REG_AW-1:0] dst;
        logic [XLEN-1:0]   result;
        logic [XLEN-1:0]   store_val;
    } exmem_t;

    typedef struct packed {
        logic              reg_wr;
        logic [REG_AW-1:0] dst;
        logic [XLEN-1:0]   value;
    } memwb_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        ifid_t           ifid;
        idex_t           idex;
        exmem_t          exmem;
        memwb_t          memwb;
    } pipe_t;

endpackage

// File: rtl/pipe5_wmem.sv
module pipe5_wmem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [WIDTH-1:0]          wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end

    // R2: a word written through the port is held by the array afterwards
    a_r2_mem_written: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int AW    = 5,
    parameter int WIDTH = 32,
    parameter int NRD   = 3,
    localparam int NREG = 2 ** AW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] regs_d [NREG];
    logic [WIDTH-1:0] regs_q [NREG];
    logic             wr_live;

    assign wr_live = wr_en && (wr_addr != '0);

    always_comb begin
        regs_d = regs_q;
        if (wr_live) begin
            regs_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    // register 0 is hard zero; a write in flight is passed straight through
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = (rd_addr[g] == '0)                 ? '0 :
                            (wr_live && wr_addr == rd_addr[g]) ? wr_data :
                                                                 regs_q[rd_addr[g]];
    end

    // R6: a write-back lands in storage for every later reader
    a_r6_reg_written: assert property (@(posedge clk) disable iff (rst)
        wr_live |=> regs_q[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [ILEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [REG_AW-1:0] rs,
    output logic [REG_AW-1:0] rt,
    output logic [XLEN-1:0]   imm
);

    logic [OP_W-1:0]   op;
    logic [REG_AW-1:0] rd;

    assign op  = instr[31:26];
    assign rs  = instr[25:21];
    assign rt  = instr[20:16];
    assign rd  = instr[15:11];
    assign imm = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_ADD:   begin ctrl.reg_wr = 1'b1; ctrl.dst = rd; end
            OP_SUB:   begin ctrl.reg_wr = 1'b1; ctrl.dst = rd; ctrl.alu_op = ALU_SUB; end
            OP_AND:   begin ctrl.reg_wr = 1'b1; ctrl.dst = rd; ctrl.alu_op = ALU_AND; end
            OP_OR:    begin ctrl.reg_wr = 1'b1; ctrl.dst = rd; ctrl.alu_op = ALU_OR;  end
            OP_LOAD:  begin ctrl.reg_wr = 1'b1; ctrl.dst = rt; ctrl.mem_rd = 1'b1; end
            OP_STORE: begin ctrl.mem_wr = 1'b1; end
            default:  begin end
        endcase
    end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    parameter int DMEM_DEPTH = 256,
    localparam int IMEM_AW   = $clog2(IMEM_DEPTH),
    localparam int DMEM_AW   = $clog2(DMEM_DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_imem_we,
    input  logic [IMEM_AW-1:0]  ld_imem_addr,
    input  logic [ILEN-1:0]     ld_imem_data,
    input  logic                ld_dmem_we,
    input  logic [DMEM_AW-1:0]  ld_dmem_addr,
    input  logic [XLEN-1:0]     ld_dmem_data,
    input  logic                ld_reg_we,
    input  logic [REG_AW-1:0]   ld_reg_addr,
    input  logic [XLEN-1:0]     ld_reg_data,
    input  logic [REG_AW-1:0]   peek_reg_addr,
    output logic [XLEN-1:0]     peek_reg_data,
    input  logic [DMEM_AW-1:0]  peek_dmem_addr,
    output logic [XLEN-1:0]     peek_dmem_data,
    output logic                ret_valid,
    output logic [REG_AW-1:0]   ret_reg,
    output logic [XLEN-1:0]     ret_data,
    output logic                st_valid,
    output logic [DMEM_AW-1:0]  st_addr,
    output logic [XLEN-1:0]     st_data
);

    pipe_t s_d, s_q;

    // ---------------- fetch: instruction memory ----------------
    logic [0:0][IMEM_AW-1:0] im_raddr;
    logic [0:0][ILEN-1:0]    im_rdata;

    assign im_raddr = s_q.pc[IMEM_AW+1:2];

    pipe5_wmem #(.DEPTH(IMEM_DEPTH), .WIDTH(ILEN), .NRD(1)) u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (ld_imem_we),
        .waddr (ld_imem_addr),
        .wdata (ld_imem_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    // ---------------- decode and register read ----------------
    ctrl_t             dec_ctrl;
    logic [REG_AW-1:0] dec_rs, dec_rt;
    logic [XLEN-1:0]   dec_imm;

    pipe5_decode u_dec (
        .instr (s_q.ifid.instr),
        .ctrl  (dec_ctrl),
        .rs    (dec_rs),
        .rt    (dec_rt),
        .imm   (dec_imm)
    );

    logic                      rf_we;
    logic [REG_AW-1:0]         rf_waddr;
    logic [XLEN-1:0]           rf_wdata;
    logic [2:0][REG_AW-1:0]    rf_raddr;
    logic [2:0][XLEN-1:0]      rf_rdata;

    assign rf_we    = ld_reg_we | s_q.memwb.reg_wr;
    assign rf_waddr = ld_reg_we ? ld_reg_addr : s_q.memwb.dst;
    assign rf_wdata = ld_reg_we ? ld_reg_data : s_q.memwb.value;
    assign rf_raddr = {peek_reg_addr, dec_rt, dec_rs};

    pipe5_regfile #(.AW(REG_AW), .WIDTH(XLEN), .NRD(3)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_we),
        .wr_addr (rf_waddr),
        .wr_data (rf_wdata),
        .rd_addr (rf_raddr),
        .rd_data (rf_rdata)
    );

    assign peek_reg_data = rf_rdata[2];

    // ---------------- execute: ALU plus separate address adder ----------------
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] eff_addr;

    pipe5_alu u_alu (
        .op (s_q.idex.ctrl.alu_op),
        .a  (s_q.idex.opa),
        .b  (s_q.idex.opb),
        .y  (alu_y)
    );

    assign eff_addr = s_q.idex.opa + s_q.idex.imm;

    // ---------------- memory: data memory ----------------
    logic                    dm_we;
    logic [DMEM_AW-1:0]      dm_waddr;
    logic [XLEN-1:0]         dm_wdata;
    logic [1:0][DMEM_AW-1:0] dm_raddr;
    logic [1:0][XLEN-1:0]    dm_rdata;

    assign dm_we    = ld_dmem_we | s_q.exmem.mem_wr;
    assign dm_waddr = ld_dmem_we ? ld_dmem_addr : s_q.exmem.result[DMEM_AW-1:0];
    assign dm_wdata = ld_dmem_we ? ld_dmem_data : s_q.exmem.store_val;
    assign dm_raddr = {peek_dmem_addr, s_q.exmem.result[DMEM_AW-1:0]};

    pipe5_wmem #(.DEPTH(DMEM_DEPTH), .WIDTH(XLEN), .NRD(2)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata)
    );

    assign peek_dmem_data = dm_rdata[1];

    // ---------------- next-state ----------------
    always_comb begin
        s_d = s_q;

        s_d.pc         = s_q.pc + XLEN'(4);
        s_d.ifid.instr = im_rdata[0];

        s_d.idex.ctrl = dec_ctrl;
        s_d.idex.opa  = rf_rdata[0];
        s_d.idex.opb  = rf_rdata[1];
        s_d.idex.imm  = dec_imm;

        s_d.exmem.mem_rd    = s_q.idex.ctrl.mem_rd;
        s_d.exmem.mem_wr    = s_q.idex.ctrl.mem_wr;
        s_d.exmem.reg_wr    = s_q.idex.ctrl.reg_wr;
        s_d.exmem.dst       = s_q.idex.ctrl.dst;
        s_d.exmem.result    = (s_q.idex.ctrl.mem_rd | s_q.idex.ctrl.mem_wr) ? eff_addr : alu_y;
        s_d.exmem.store_val = s_q.idex.opb;

        s_d.memwb.reg_wr = s_q.exmem.reg_wr;
        s_d.memwb.dst    = s_q.exmem.dst;
        s_d.memwb.value  = s_q.exmem.mem_rd ? dm_rdata[0] : s_q.exmem.result;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- observation ports ----------------
    assign ret_valid = s_q.memwb.reg_wr && (s_q.memwb.dst != '0);
    assign ret_reg   = s_q.memwb.dst;
    assign ret_data  = s_q.memwb.value;
    assign st_valid  = s_q.exmem.mem_wr;
    assign st_addr   = s_q.exmem.result[DMEM_AW-1:0];
    assign st_data   = s_q.exmem.store_val;

    logic [XLEN-IMEM_AW-1+XLEN-DMEM_AW-1:0] unused_bits;
    assign unused_bits = {s_q.pc[XLEN-1:IMEM_AW+2], s_q.pc[1:0], s_q.exmem.result[XLEN-1:DMEM_AW]};

    // ---------------- assertions ----------------
    // R8: the PC moves by one word per cycle once out of reset
    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        !rst |=> s_q.pc == $past(s_q.pc) + XLEN'(4));

    // R2: a store leaving the memory stage never becomes a register write
    a_r2_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        s_q.exmem.mem_wr |=> !s_q.memwb.reg_wr);

    // R4: the destination number follows its instruction into write-back
    a_r4_dst_carried: assert property (@(posedge clk) disable iff (rst)
        s_q.exmem.reg_wr |=> s_q.memwb.reg_wr && s_q.memwb.dst == $past(s_q.exmem.dst));

    // R3: a load flag decoded in one stage arrives in the next one cycle later
    a_r3_load_flag_advances: assert property (@(posedge clk) disable iff (rst)
        s_q.idex.ctrl.mem_rd |=> s_q.exmem.mem_rd);

endmodule

// File: tb/pipe5_core_bench.sv
module pipe5_core_bench;

    localparam int IDEPTH = 64;
    localparam int DDEPTH = 128;
    localparam int IAW    = $clog2(IDEPTH);
    localparam int DAW    = $clog2(DDEPTH);

    localparam logic [5:0] K_NOP = 6'd0, K_ADD = 6'd1, K_SUB = 6'd2, K_AND = 6'd3,
                           K_OR  = 6'd4, K_LW  = 6'd5, K_SW  = 6'd6, K_BAD = 6'd63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic            ld_imem_we = 1'b0;
    logic [IAW-1:0]  ld_imem_addr = '0;
    logic [31:0]     ld_imem_data = '0;
    logic            ld_dmem_we = 1'b0;
    logic [DAW-1:0]  ld_dmem_addr = '0;
    logic [31:0]     ld_dmem_data = '0;
    logic            ld_reg_we = 1'b0;
    logic [4:0]      ld_reg_addr = '0;
    logic [31:0]     ld_reg_data = '0;
    logic [4:0]      peek_reg_addr = '0;
    logic [31:0]     peek_reg_data;
    logic [DAW-1:0]  peek_dmem_addr = '0;
    logic [31:0]     peek_dmem_data;
    logic            ret_valid;
    logic [4:0]      ret_reg;
    logic [31:0]     ret_data;
    logic            st_valid;
    logic [DAW-1:0]  st_addr;
    logic [31:0]     st_data;

    always #2 clk = ~clk;

    pipe5_core #(.IMEM_DEPTH(IDEPTH), .DMEM_DEPTH(DDEPTH)) u_pipe5_core (
        .clk(clk), .rst(rst),
        .ld_imem_we(ld_imem_we), .ld_imem_addr(ld_imem_addr), .ld_imem_data(ld_imem_data),
        .ld_dmem_we(ld_dmem_we), .ld_dmem_addr(ld_dmem_addr), .ld_dmem_data(ld_dmem_data),
        .ld_reg_we(ld_reg_we), .ld_reg_addr(ld_reg_addr), .ld_reg_data(ld_reg_data),
        .peek_reg_addr(peek_reg_addr), .peek_reg_data(peek_reg_data),
        .peek_dmem_addr(peek_dmem_addr), .peek_dmem_data(peek_dmem_data),
        .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_data(ret_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int          at;
        logic [31:0] key;
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t exp_ret[$];
    item_t exp_st[$];
    logic [31:0] prog [IDEPTH];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs, int rt);
        return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
    endfunction

    function automatic logic [31:0] enc_m(logic [5:0] op, int rt, int rs, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    // driver side of the scoreboard: instruction index k retires after edge k+4
    task automatic push_ret(input int k, input int r, input logic [31:0] v, input string tag);
        item_t it;
        it.at = k + 4; it.key = 32'(r); it.val = v; it.tag = tag;
        exp_ret.push_back(it);
    endtask

    task automatic push_st(input int k, input int a, input logic [31:0] v, input string tag);
        item_t it;
        it.at = k + 3; it.key = 32'(a); it.val = v; it.tag = tag;
        exp_st.push_back(it);
    endtask

    function automatic logic [31:0] dinit(int k);
        return 32'h100 + 32'(k);
    endfunction

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ret_valid) begin
                if (exp_ret.size() == 0) begin
                    check(1'b0, "R4", "unexpected retire reg", 32'(ret_reg), 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = exp_ret.pop_front();
                    check(32'(ret_reg) == it.key, it.tag, "retire reg", 32'(ret_reg), it.key);
                    check(ret_data == it.val, it.tag, "retire data", ret_data, it.val);
                    check(cyc == it.at, "R3", "retire cycle", 32'(cyc), 32'(it.at));
                end
            end
            if (st_valid) begin
                if (exp_st.size() == 0) begin
                    check(1'b0, "R2", "unexpected store addr", 32'(st_addr), 32'hFFFF_FFFF);
                end else begin
                    item_t it;
                    it = exp_st.pop_front();
                    check(32'(st_addr) == it.key, it.tag, "store addr", 32'(st_addr), it.key);
                    check(st_data == it.val, it.tag, "store data", st_data, it.val);
                    check(cyc == it.at, "R3", "store cycle", 32'(cyc), 32'(it.at));
                end
            end
        end
    end

    task automatic peek_reg(input int r, input logic [31:0] exp, input string tag);
        @(negedge clk);
        peek_reg_addr = 5'(r);
        #1;
        check(peek_reg_data == exp, tag, $sformatf("final r%0d", r), peek_reg_data, exp);
    endtask

    task automatic peek_mem(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        peek_dmem_addr = DAW'(a);
        #1;
        check(peek_dmem_data == exp, tag, $sformatf("final mem[%0d]", a), peek_dmem_data, exp);
    endtask

    initial begin
        for (int i = 0; i < IDEPTH; i++) prog[i] = 32'd0;
        prog[0]  = enc_r(K_ADD, 3, 10, 11);
        prog[1]  = enc_m(K_LW, 8, 3, 50);
        prog[2]  = enc_r(K_SUB, 11, 8, 7);
        prog[5]  = enc_m(K_LW, 9, 3, 50);
        prog[6]  = enc_r(K_AND, 12, 9, 13);
        prog[8]  = enc_r(K_OR, 14, 9, 1);
        prog[10] = enc_r(K_ADD, 15, 14, 14);
        prog[11] = enc_m(K_SW, 3, 6, -2);
        prog[12] = enc_r(K_ADD, 0, 1, 2);
        prog[13] = enc_r(K_ADD, 16, 0, 5);
        prog[14] = enc_r(K_SUB, 17, 2, 6);
        prog[15] = enc_m(K_LW, 18, 6, -2);
        prog[16] = enc_m(K_SW, 1, 20, 0);
        prog[17] = enc_m(K_LW, 19, 20, 0);
        prog[18] = enc_r(K_BAD, 24, 1, 2);
        prog[19] = enc_r(K_OR, 21, 22, 23);

        // R10: load everything through the load ports while reset is held
        repeat (2) @(negedge clk);
        for (int i = 0; i < IDEPTH; i++) begin
            @(negedge clk);
            ld_imem_we = 1'b1; ld_imem_addr = IAW'(i); ld_imem_data = prog[i];
        end
        @(negedge clk); ld_imem_we = 1'b0;
        for (int i = 0; i < DDEPTH; i++) begin
            @(negedge clk);
            ld_dmem_we = 1'b1; ld_dmem_addr = DAW'(i); ld_dmem_data = dinit(i);
        end
        @(negedge clk); ld_dmem_we = 1'b0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_reg_we = 1'b1; ld_reg_addr = 5'(i); ld_reg_data = 32'(2 * i);
        end
        @(negedge clk); ld_reg_we = 1'b0;

        @(negedge clk);
        check(ret_valid == 1'b0, "R8", "retire idle in reset", 32'(ret_valid), 32'd0);
        check(st_valid == 1'b0, "R8", "store idle in reset", 32'(st_valid), 32'd0);

        // expectations (registers preset to 2*index, memory word k = 0x100+k)
        push_ret(0,  3,  32'd42, "R1");                   // add
        push_ret(1,  8,  dinit(6 + 50), "R5");            // base r3 still old (6)
        push_ret(2,  11, 32'd16 - 32'd14, "R5");          // r8 still old (16)
        push_ret(5,  9,  dinit(42 + 50), "R2");           // word 92
        push_ret(6,  12, 32'd18 & 32'd26, "R5");          // r9 old at gap one
        push_ret(8,  14, dinit(92) | 32'd2, "R6");        // gap three sees new r9
        push_ret(10, 15, 32'd28 + 32'd28, "R5");          // gap two sees old r14
        push_st (11, 10, 32'd42, "R2");                   // store r3 to 12-2
        push_ret(13, 16, 32'd10, "R7");                   // r0 still zero
        push_ret(14, 17, 32'd4 - 32'd12, "R1");           // wraps negative
        push_ret(15, 18, 32'd42, "R2");                   // load back stored word
        push_st (16, 40, 32'd2, "R2");
        push_ret(17, 19, 32'd2, "R2");                    // load right after store
        push_ret(19, 21, 32'd44 | 32'd46, "R9");          // after undefined opcode

        rst = 1'b0;

        while (cyc < 40) @(negedge clk);

        check(exp_ret.size() == 0, "R4", "retires left", 32'(exp_ret.size()), 32'd0);
        check(exp_st.size() == 0, "R2", "stores left", 32'(exp_st.size()), 32'd0);

        peek_reg(0,  32'd0, "R7");
        peek_reg(1,  32'd2, "R10");
        peek_reg(31, 32'd62, "R10");
        peek_reg(3,  32'd42, "R3");
        peek_reg(8,  dinit(56), "R5");
        peek_reg(11, 32'd2, "R5");
        peek_reg(18, 32'd42, "R2");
        peek_reg(24, 32'd48, "R9");
        peek_reg(21, 32'd46, "R8");
        peek_mem(10, 32'd42, "R2");
        peek_mem(40, 32'd2, "R2");
        peek_mem(92, dinit(92), "R10");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(4 * 5000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule